// File: doc/BRIEF.md
# Asynchronous Serial Transmitter with Break and Idle Characters

This block turns parallel characters into an asynchronous serial stream. A single holding buffer is written from the parallel side. The transmitter moves the buffer into a shift register when the previous character has finished. Each data character goes out with a low start bit, then the data bits with the least significant bit first, then a high stop bit. One mode input selects 8 or 9 data bits. Every bit lasts a fixed number of baud ticks, 16 by default. The baud tick comes from a rate generator outside the block.

The transmitter can also send two special characters. A break character is low for the whole character length. An idle character is high for the whole character length. Each time transmission is enabled, an idle character goes out first as a preamble. Holding the break request sends breaks back to back. When the request is released, one high bit follows the last break. If the enable input is dropped and raised again while a character is being sent, one idle character is queued behind that character. A buffer-empty flag shows when the buffer can be written, and it can raise an interrupt request.

The control is a state machine with seven states:

| State | Meaning |
|---|---|
| `S_OFF` | disabled, line high |
| `S_WAIT` | enabled, nothing to send |
| `S_PRE` | preamble idle character |
| `S_DATA` | data character |
| `S_BRK` | break character |
| `S_MARK` | single high bit after a break |
| `S_QIDLE` | queued idle character |

The transitions are:

- `S_OFF` goes to `S_PRE` when enable is seen.
- At the end of any character other than a break, the next state is chosen in this priority order: `S_OFF` if enable is low, then `S_QIDLE` if an idle is queued, then `S_BRK` if a break is requested, then `S_DATA` if the buffer is full, otherwise `S_WAIT`.
- `S_WAIT` makes the same choice on every cycle.
- At the end of a break, the machine goes back to `S_BRK` if the break request and enable are both still high; otherwise it goes to `S_MARK`.

Top module: `sertx_core`

## Requirements
- R1: After reset `txd` is 1, `tx_empty` is 1, and `irq` follows `tie`.
- R2: With transmission disabled, or with nothing to send, `txd` stays at 1.
- R3: When `tx_en` is raised from the disabled state, the first thing sent is an idle preamble: all ones, 10 bit times long, or 11 when `long_char`=1.
- R4: A data character is sent in this order: a start bit of 0, then the data with bit 0 first, then a stop bit of 1. It carries `wr_data[7:0]` when `long_char`=0, or `wr_data[8:0]` when `long_char`=1. Each bit lasts 16 asserted `baud_tick` cycles.
- R5: A write clears `tx_empty` from the next cycle. The move of the buffer into the shift register sets `tx_empty` again. A character written during a transfer follows the current one with no gap.
- R6: `irq` is 1 exactly when `tx_empty` and `tie` are both 1.
- R7: While `brk_req`=1, break characters are sent back to back. A break is all zeros with the same length as a data character. A pending break takes priority over a full buffer and leaves the buffer untouched.
- R8: Once `brk_req` is low at the end of a break, exactly one bit time of 1 is sent before the next character.
- R9: When `tx_en` is cleared during a character, that character completes. The line then stays at 1, and any data waiting in the buffer is kept (`tx_empty` stays 0).
- R10: If `tx_en` falls and rises again during a character, one idle character (all ones, full length) is sent before the next data character.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low synchronous reset |
| wr_en | input | 1 | write strobe for the holding buffer |
| wr_data | input | 9 | character to buffer (bit 8 used only in long mode) |
| tx_en | input | 1 | transmit enable |
| brk_req | input | 1 | send break characters while high |
| long_char | input | 1 | 0: 8 data bits, 1: 9 data bits |
| tie | input | 1 | interrupt enable for the empty flag |
| baud_tick | input | 1 | one pulse per 1/16 bit time |
| txd | output | 1 | serial line |
| tx_empty | output | 1 | holding buffer can accept a character |
| irq | output | 1 | interrupt request |

## Verification
The bench compares the line with the expected levels at the middle of each bit.

- **Preamble.** It checks that a preamble leads every enable. A design that skips it would put the start bit ten bit times early.
- **Break release.** A design that omits the high bit after a break would start the data character one bit early. A design that lets the buffer win over a pending break would send data where zeros belong.
- **Toggling the enable mid-character.** This must insert an idle character before the second byte. A design without the queue sends that byte right away.
- **Dropping the enable.** The bench then confirms that the buffered byte stays unsent and the empty flag stays clear. A design that stops abruptly or drains the buffer fails on the line or on the flag.

// File: rtl/sertx_pkg.sv
package sertx_pkg;

    typedef enum logic [2:0] {
        S_OFF,
        S_WAIT,
        S_PRE,
        S_DATA,
        S_BRK,
        S_MARK,
        S_QIDLE
    } tx_state_t;

    typedef enum logic [1:0] {
        PAT_ONES,
        PAT_ZEROS,
        PAT_DATA,
        PAT_MARK
    } pat_t;

endpackage

// File: rtl/sertx_bittimer.sv
module sertx_bittimer #(
    parameter int TICKS_PER_BIT = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic baud_tick,
    output logic bit_end
);
    localparam int CW = $clog2(TICKS_PER_BIT);
    localparam logic [CW-1:0] LAST = CW'(TICKS_PER_BIT - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (restart) begin
            cnt <= '0;
        end else if (baud_tick) begin
            cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
        end
    end

    assign bit_end = baud_tick && (cnt == LAST);

endmodule

// File: rtl/sertx_shifter.sv
module sertx_shifter
    import sertx_pkg::*;
#(
    parameter int DATA_MAX = 9
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load,
    input  pat_t                pat,
    input  logic                long_char,
    input  logic [DATA_MAX-1:0] data,
    input  logic                bit_end,
    output logic                txd,
    output logic                char_done
);
    localparam int SR_W = DATA_MAX + 2;
    localparam int LW   = $clog2(SR_W + 1);
    localparam logic [LW-1:0] LEN_LONG  = LW'(SR_W);
    localparam logic [LW-1:0] LEN_SHORT = LW'(SR_W - 1);

    logic [SR_W-1:0] sr;
    logic [SR_W-1:0] sr_load;
    logic [LW-1:0]   left;
    logic [LW-1:0]   len_load;

    always_comb begin
        len_load = long_char ? LEN_LONG : LEN_SHORT;
        unique case (pat)
            PAT_ONES:  sr_load = '1;
            PAT_ZEROS: sr_load = '0;
            PAT_DATA:  sr_load = long_char ? {1'b1, data, 1'b0}
                                           : {2'b11, data[DATA_MAX-2:0], 1'b0};
            PAT_MARK: begin
                sr_load  = '1;
                len_load = LW'(1);
            end
            default:   sr_load = '1;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr   <= '1;
            left <= '0;
        end else if (load) begin
            sr   <= sr_load;
            left <= len_load;
        end else if (bit_end && left != '0) begin
            sr   <= {1'b1, sr[SR_W-1:1]};
            left <= left - 1'b1;
        end
    end

    assign txd       = sr[0];
    assign char_done = bit_end && (left == LW'(1));

endmodule

// File: rtl/sertx_ctrl.sv
module sertx_ctrl
    import sertx_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      tx_en,
    input  logic      brk_req,
    input  logic      buf_full,
    input  logic      char_done,
    output tx_state_t state,
    output logic      load,
    output pat_t      pat,
    output logic      take_buf
);
    tx_state_t nxt;
    tx_state_t pick;
    logic      idle_q;
    logic      en_d;
    logic      busy;

    function automatic logic is_char(tx_state_t s);
        return (s == S_PRE) || (s == S_DATA) || (s == S_BRK) ||
               (s == S_MARK) || (s == S_QIDLE);
    endfunction

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= S_OFF;
        end else begin
            state <= nxt;
        end
    end

    // next-state decision
    always_comb begin
        if (!tx_en) begin
            pick = S_OFF;
        end else if (idle_q) begin
            pick = S_QIDLE;
        end else if (brk_req) begin
            pick = S_BRK;
        end else if (buf_full) begin
            pick = S_DATA;
        end else begin
            pick = S_WAIT;
        end

        nxt = state;
        unique case (state)
            S_OFF:   if (tx_en) nxt = S_PRE;
            S_WAIT:  nxt = pick;
            S_PRE, S_DATA, S_MARK, S_QIDLE: if (char_done) nxt = pick;
            S_BRK:   if (char_done) nxt = (brk_req && tx_en) ? S_BRK : S_MARK;
            default: nxt = S_OFF;
        endcase
    end

    // outputs to shifter and buffer
    always_comb begin
        busy     = is_char(state);
        load     = is_char(nxt) && ((nxt != state) || char_done);
        take_buf = load && (nxt == S_DATA);
        unique case (nxt)
            S_BRK:   pat = PAT_ZEROS;
            S_DATA:  pat = PAT_DATA;
            S_MARK:  pat = PAT_MARK;
            default: pat = PAT_ONES;
        endcase
    end

    // queued idle after enable toggle during a character
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idle_q <= 1'b0;
            en_d   <= 1'b0;
        end else begin
            en_d <= tx_en;
            if ((load && nxt == S_QIDLE) || nxt == S_OFF) begin
                idle_q <= 1'b0;
            end else if (busy && tx_en && !en_d) begin
                idle_q <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/sertx_core.sv
module sertx_core
    import sertx_pkg::*;
#(
    parameter int DATA_MAX      = 9,
    parameter int TICKS_PER_BIT = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [DATA_MAX-1:0] wr_data,
    input  logic                tx_en,
    input  logic                brk_req,
    input  logic                long_char,
    input  logic                tie,
    input  logic                baud_tick,
    output logic                txd,
    output logic                tx_empty,
    output logic                irq
);
    logic [DATA_MAX-1:0] buf_data;
    logic                buf_full;
    logic                load;
    logic                take_buf;
    logic                bit_end;
    logic                char_done;
    pat_t                pat;
    tx_state_t           fsm_state;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            buf_full <= 1'b0;
            buf_data <= '0;
        end else if (wr_en) begin
            buf_full <= 1'b1;
            buf_data <= wr_data;
        end else if (take_buf) begin
            buf_full <= 1'b0;
        end
    end

    assign tx_empty = !buf_full;
    assign irq      = tx_empty && tie;

    sertx_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .tx_en     (tx_en),
        .brk_req   (brk_req),
        .buf_full  (buf_full),
        .char_done (char_done),
        .state     (fsm_state),
        .load      (load),
        .pat       (pat),
        .take_buf  (take_buf)
    );

    sertx_bittimer #(.TICKS_PER_BIT(TICKS_PER_BIT)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart   (load),
        .baud_tick (baud_tick),
        .bit_end   (bit_end)
    );

    sertx_shifter #(.DATA_MAX(DATA_MAX)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .pat       (pat),
        .long_char (long_char),
        .data      (buf_data),
        .bit_end   (bit_end),
        .txd       (txd),
        .char_done (char_done)
    );

endmodule

// File: rtl/sertx_core_chk.sv
module sertx_core_chk
    import sertx_pkg::*;
(
    input logic      clk,
    input logic      rst_n,
    input tx_state_t state,
    input logic      txd,
    input logic      tx_empty,
    input logic      wr_en,
    input logic      tie,
    input logic      irq
);
    AST_OFF_LINE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_OFF || state == S_WAIT) |-> txd);                         // R2
    AST_IDLE_CHAR_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_PRE || state == S_QIDLE) |-> txd);                        // R3
    AST_WRITE_CLEARS_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !tx_empty);                                                 // R5
    AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        !tie |-> !irq);                                                       // R6
    AST_BREAK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_BRK) |-> !txd);                                           // R7
    AST_MARK_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_MARK) |-> txd);                                           // R8

endmodule

bind sertx_core sertx_core_chk chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .state    (fsm_state),
    .txd      (txd),
    .tx_empty (tx_empty),
    .wr_en    (wr_en),
    .tie      (tie),
    .irq      (irq)
);

// File: tb/sertx_core_tb_top.sv
module sertx_core_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [8:0] wr_data = '0;
    logic       tx_en = 1'b0;
    logic       brk_req = 1'b0;
    logic       long_char = 1'b0;
    logic       tie = 1'b0;
    logic       baud_tick = 1'b1;
    logic       txd;
    logic       tx_empty;
    logic       irq;

    int n_chk = 0;
    int n_bad = 0;
    int pos = 0;
    logic mon_go = 1'b0;
    logic mon_busy = 1'b0;

    typedef struct {
        logic  v;
        string req;
    } exp_t;
    exp_t exp_q[$];

    always #2 clk = ~clk;

    sertx_core dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .tx_en     (tx_en),
        .brk_req   (brk_req),
        .long_char (long_char),
        .tie       (tie),
        .baud_tick (baud_tick),
        .txd       (txd),
        .tx_empty  (tx_empty),
        .irq       (irq)
    );

    task automatic chk(string req, string what, logic act, logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%b expected=%b", req, what, act, exp);
        end
    endtask

    task automatic push_bits(int n, logic v, string req);
        for (int i = 0; i < n; i++) exp_q.push_back('{v: v, req: req});
    endtask

    task automatic push_data(int d, logic lng, string req);
        push_bits(1, 1'b0, req);
        for (int i = 0; i < (lng ? 9 : 8); i++) push_bits(1, d[i], req);
        push_bits(1, 1'b1, req);
    endtask

    task automatic write_buf(int d);
        @(negedge clk);
        wr_en = 1'b1;
        wr_data = 9'(d);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic start_run();
        @(negedge clk);
        tx_en = 1'b1;
        mon_busy = 1'b1;
        mon_go = 1'b1;
        @(posedge clk);
        pos = 0;
    endtask

    task automatic goto_bit(int b);
        repeat (16 * b + 4 - pos) @(posedge clk);
        pos = 16 * b + 4;
        @(negedge clk);
    endtask

    task automatic end_run();
        wait (!mon_busy);
        repeat (20) @(posedge clk);
        @(negedge clk);
    endtask

    // monitor: compares the line at the middle of each bit
    initial begin
        forever begin
            wait (mon_go);
            @(posedge clk);
            mon_go = 1'b0;
            while (exp_q.size() > 0) begin
                exp_t e;
                repeat (8) @(posedge clk);
                #1;
                e = exp_q.pop_front();
                chk(e.req, "txd bit", txd, e.v);
                repeat (8) @(posedge clk);
            end
            mon_busy = 1'b0;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        // R1 reset state
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "txd after reset", txd, 1'b1);
        chk("R1", "tx_empty after reset", tx_empty, 1'b1);
        chk("R1", "irq with tie=0", irq, 1'b0);
        tie = 1'b1;
        #1;
        chk("R6", "irq with empty and tie", irq, 1'b1);
        repeat (40) @(posedge clk);
        @(negedge clk);
        chk("R2", "disabled line", txd, 1'b1);

        // R3 R4 R5 R9: 8-bit preamble, data, disable mid-frame
        write_buf(9'h0A5);
        chk("R5", "tx_empty after write", tx_empty, 1'b0);
        chk("R6", "irq after write", irq, 1'b0);
        push_bits(10, 1'b1, "R3");
        push_data(9'h0A5, 1'b0, "R4");
        push_bits(10, 1'b1, "R9");
        start_run();
        goto_bit(9);
        chk("R5", "tx_empty before transfer", tx_empty, 1'b0);
        goto_bit(10);
        chk("R5", "tx_empty after transfer", tx_empty, 1'b1);
        chk("R6", "irq after transfer", irq, 1'b1);
        goto_bit(12);
        wr_en = 1'b1;
        wr_data = 9'h03C;
        tx_en = 1'b0;
        @(negedge clk);
        wr_en = 1'b0;
        pos += 1;
        end_run();
        chk("R9", "buffer kept after disable", tx_empty, 1'b0);
        chk("R2", "line after disable", txd, 1'b1);

        // R4 R5: 9-bit mode, back-to-back characters
        long_char = 1'b1;
        write_buf(9'h1C3);
        push_bits(11, 1'b1, "R3");
        push_data(9'h1C3, 1'b1, "R4");
        push_data(9'h055, 1'b1, "R5");
        push_bits(5, 1'b1, "R9");
        start_run();
        goto_bit(12);
        chk("R5", "empty during 9-bit frame", tx_empty, 1'b1);
        wr_en = 1'b1;
        wr_data = 9'h055;
        @(negedge clk);
        wr_en = 1'b0;
        pos += 1;
        goto_bit(24);
        tx_en = 1'b0;
        end_run();

        // R7 R8: break priority, repeat, release then mark
        long_char = 1'b0;
        brk_req = 1'b1;
        write_buf(9'h00F);
        push_bits(10, 1'b1, "R3");
        push_bits(20, 1'b0, "R7");
        push_bits(1, 1'b1, "R8");
        push_data(9'h00F, 1'b0, "R8");
        push_bits(5, 1'b1, "R9");
        start_run();
        goto_bit(25);
        brk_req = 1'b0;
        goto_bit(30);
        chk("R7", "buffer untouched by break", tx_empty, 1'b0);
        goto_bit(33);
        tx_en = 1'b0;
        end_run();

        // R10: enable toggle queues an idle character
        write_buf(9'h081);
        push_bits(10, 1'b1, "R3");
        push_data(9'h081, 1'b0, "R4");
        push_bits(10, 1'b1, "R10");
        push_data(9'h042, 1'b0, "R10");
        push_bits(5, 1'b1, "R9");
        start_run();
        goto_bit(12);
        wr_en = 1'b1;
        wr_data = 9'h042;
        @(negedge clk);
        wr_en = 1'b0;
        pos += 1;
        goto_bit(13);
        tx_en = 1'b0;
        goto_bit(14);
        tx_en = 1'b1;
        goto_bit(32);
        tx_en = 1'b0;
        end_run();

        tie = 1'b0;
        #1;
        chk("R6", "irq with tie cleared", irq, 1'b0);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule